// File: doc/BRIEF.md
# Mersenne-Modulus LFSR Feedback Engine

This block keeps sixteen 31-bit words in a shift register and, on each accepted step, produces one new word from a weighted sum of five of them. The sum is taken modulo 2^31−1 rather than with XOR. Multiplying by a power of two is a 31-bit left rotation. Each addition is a 32-bit add whose carry bit is folded back into the low 31 bits. A result of zero is replaced by 2^31−1.

A mode pin picks one of two step kinds. A seeding step also folds an external 31-bit word into the sum. A running step ignores that word. Software-free control is assumed: a surrounding controller loads all sixteen cells in parallel, then issues steps, then reads every cell from the flat read-out bus.

The step request is a valid/ready stream. A step is taken in any cycle where `step_valid` and `step_ready` are both high. The request, with its mode and word, must stay stable until it is taken. `step_ready` drops during any cycle that carries a parallel load, because the load wins. `step_done` pulses in the cycle after a step is taken, when the shifted contents are visible.

Top module: `mm_lfsr_engine`

## Requirements
- R1: While `rst` is high at a clock edge, every cell becomes 0 and `step_done` becomes 0.
- R2: When `load_valid` is high at an edge, cell i takes `load_cells[31*i+30 : 31*i]` for all i in 0..15.
- R3: `step_ready` is low in every cycle where `load_valid` is high, so no step is taken there; it is high otherwise.
- R4: `step_done` is high in exactly the cycles that follow a taken step (`step_valid && step_ready` at the previous edge).
- R5: On a taken step, cell i takes the old value of cell i+1 for i in 0..14.
- R6: On a taken step with `step_seed`=0, cell 15 takes (2^15·c15 + 2^17·c13 + 2^21·c10 + 2^20·c4 + 257·c0) mod (2^31−1), and `step_word` has no effect.
- R7: On a taken step with `step_seed`=1, cell 15 takes (that weighted sum + `step_word`) mod (2^31−1).
- R8: When the new cell-15 value is 0 modulo 2^31−1, the value 2^31−1 is stored instead, never 0.
- R9: With no taken step and no load, all cells keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Parallel load strobe for all cells |
| load_cells | input | 496 | Load data, cell i at bits 31*i+30..31*i |
| step_valid | input | 1 | Step request valid |
| step_ready | output | 1 | Step request can be taken this cycle |
| step_seed | input | 1 | 1 = seeding step (adds word), 0 = running step |
| step_word | input | 31 | Word added during a seeding step |
| step_done | output | 1 | Pulses the cycle after a step is taken |
| cells | output | 496 | Read-out of all cells, same packing as load_cells |

## Verification
The first step is run from the all-zero reset state. This separates the zero-to-maximum substitution from a plain modular sum. A seeding step is also run with a word chosen so that the sum is exactly a multiple of the modulus, which exercises the substitution on a nonzero path. Random loaded states are stepped in running mode with random words, which shows that the word is ignored and that the tap positions and rotation amounts are right. A long seeding run and a random mix of steps, loads, stalls and resets then compare every cell each clock against a model that multiplies and takes the remainder directly. That model catches wrong carry folding, wrong taps, a wrong shift direction, and wrong load-versus-step priority.

// File: rtl/mm_lfsr_pkg.sv
package mm_lfsr_pkg;
  localparam int unsigned NCELLS = 16;
  // tap cells and their rotation amounts (weights 2^k)
  localparam int unsigned TAP_HI   = 15;
  localparam int unsigned TAP_MID  = 13;
  localparam int unsigned TAP_LOW  = 10;
  localparam int unsigned TAP_LOW2 = 4;
  localparam int unsigned TAP_BASE = 0;
  localparam int unsigned ROT_HI   = 15;
  localparam int unsigned ROT_MID  = 17;
  localparam int unsigned ROT_LOW  = 21;
  localparam int unsigned ROT_LOW2 = 20;
  localparam int unsigned ROT_BASE = 8;
  localparam int unsigned NTERMS   = 6;
endpackage

// File: rtl/mm_addm.sv
module mm_addm #(
  parameter int unsigned W = 31
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W:0] raw;

  always_comb begin
    raw = {1'b0, a} + {1'b0, b};
    y   = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  end

  // R8
  always_comb begin
    zero_only_from_zero_chk: assert (y != '0 || (a == '0 && b == '0));
  end
endmodule

// File: rtl/mm_feedback.sv
module mm_feedback
  import mm_lfsr_pkg::*;
#(
  parameter int unsigned W = 31
) (
  input  logic [NCELLS-1:0][W-1:0] cur,
  input  logic                     seed,
  input  logic [W-1:0]             word,
  output logic [W-1:0]             next_cell
);
  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int unsigned k);
    return (x << k) | (x >> (W - k));
  endfunction

  logic [NTERMS-1:0][W-1:0] term;
  logic [NTERMS/2-1:0][W-1:0] pair;
  logic [W-1:0] quad, v, w_add, w_sel;

  always_comb begin
    term[0] = cur[TAP_BASE];
    term[1] = rotl(cur[TAP_BASE], ROT_BASE);
    term[2] = rotl(cur[TAP_LOW2], ROT_LOW2);
    term[3] = rotl(cur[TAP_LOW],  ROT_LOW);
    term[4] = rotl(cur[TAP_MID],  ROT_MID);
    term[5] = rotl(cur[TAP_HI],   ROT_HI);
  end

  for (genvar g = 0; g < NTERMS/2; g++) begin : g_pair
    mm_addm #(.W(W)) u_add (.a(term[2*g]), .b(term[2*g+1]), .y(pair[g]));
  end

  mm_addm #(.W(W)) u_add_q (.a(pair[0]), .b(pair[1]), .y(quad));
  mm_addm #(.W(W)) u_add_v (.a(quad),    .b(pair[2]), .y(v));
  mm_addm #(.W(W)) u_add_u (.a(v),       .b(word),    .y(w_add));

  always_comb begin
    w_sel     = seed ? w_add : v;
    next_cell = (w_sel == '0) ? '1 : w_sel;
  end

  // R8
  always_comb begin
    fb_nonzero_chk: assert (next_cell != '0);
  end
endmodule

// File: rtl/mm_cell_bank.sv
module mm_cell_bank
  import mm_lfsr_pkg::*;
#(
  parameter int unsigned W = 31
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_en,
  input  logic [NCELLS-1:0][W-1:0] load_data,
  input  logic                     shift_en,
  input  logic [W-1:0]             new_cell,
  output logic [NCELLS-1:0][W-1:0] cur
);
  for (genvar i = 0; i < NCELLS; i++) begin : g_cell
    logic [W-1:0] nxt;
    if (i == NCELLS - 1) begin : g_top
      assign nxt = new_cell;
    end else begin : g_mid
      assign nxt = cur[i+1];
    end
    always_ff @(posedge clk) begin
      if (rst)           cur[i] <= '0;
      else if (load_en)  cur[i] <= load_data[i];
      else if (shift_en) cur[i] <= nxt;
    end
  end

  // R5
  shift_down_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load_en) |=> (cur[0] == $past(cur[1]) && cur[NCELLS-2] == $past(cur[NCELLS-1])));
  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> cur == $past(load_data));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !shift_en) |=> $stable(cur));
endmodule

// File: rtl/mm_lfsr_engine.sv
module mm_lfsr_engine
  import mm_lfsr_pkg::*;
#(
  parameter int unsigned CELL_W = 31,
  localparam int unsigned BUS_W = NCELLS * CELL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_valid,
  input  logic [BUS_W-1:0]  load_cells,
  input  logic              step_valid,
  output logic              step_ready,
  input  logic              step_seed,
  input  logic [CELL_W-1:0] step_word,
  output logic              step_done,
  output logic [BUS_W-1:0]  cells
);
  logic [NCELLS-1:0][CELL_W-1:0] cur, ld;
  logic [CELL_W-1:0] fb;
  logic fire;

  assign ld         = load_cells;
  assign cells      = cur;
  assign step_ready = !load_valid;
  assign fire       = step_valid && step_ready;

  mm_feedback #(.W(CELL_W)) u_fb (
    .cur(cur), .seed(step_seed), .word(step_word), .next_cell(fb)
  );

  mm_cell_bank #(.W(CELL_W)) u_bank (
    .clk(clk), .rst(rst), .load_en(load_valid), .load_data(ld),
    .shift_en(fire), .new_cell(fb), .cur(cur)
  );

  always_ff @(posedge clk) begin
    if (rst) step_done <= 1'b0;
    else     step_done <= fire;
  end

  // R4
  done_after_step_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> step_done);
  // R4
  done_only_after_step_chk: assert property (@(posedge clk) disable iff (rst)
    step_done |-> $past(fire));
  // R3
  load_blocks_step_chk: assert property (@(posedge clk) disable iff (rst)
    load_valid |-> !step_ready);
  // R8
  top_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !load_valid) |=> cur[NCELLS-1] != '0);
endmodule

// File: tb/sim_mm_lfsr_engine.sv
`timescale 1ns/1ps
module sim_mm_lfsr_engine;
  localparam longint M = 64'h7FFF_FFFF;
  logic clk = 0, rst = 1, load_valid = 0, step_valid = 0, step_seed = 0;
  logic [495:0] load_cells = '0;
  logic [30:0] step_word = '0;
  logic step_ready, step_done;
  logic [495:0] cells;
  int checks = 0, fails = 0;
  longint rc[16];
  bit rdone = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  mm_lfsr_engine u0 (.clk(clk), .rst(rst), .load_valid(load_valid), .load_cells(load_cells),
    .step_valid(step_valid), .step_ready(step_ready), .step_seed(step_seed),
    .step_word(step_word), .step_done(step_done), .cells(cells));

  function automatic longint wsum();
    longint v;
    v = (rc[15] * (64'd1 << 15)) % M;
    v = (v + (rc[13] * (64'd1 << 17)) % M) % M;
    v = (v + (rc[10] * (64'd1 << 21)) % M) % M;
    v = (v + (rc[4]  * (64'd1 << 20)) % M) % M;
    v = (v + (rc[0] * 257) % M) % M;
    return v;
  endfunction

  task automatic model_edge();
    bit taken;
    longint v;
    taken = step_valid && !load_valid;
    if (rst) begin
      for (int i = 0; i < 16; i++) rc[i] = 0;
      rdone = 0;
    end else begin
      if (load_valid) for (int i = 0; i < 16; i++) rc[i] = longint'(load_cells[31*i +: 31]);
      else if (taken) begin
        v = wsum();
        if (step_seed) v = (v + longint'(step_word)) % M;
        if (v == 0) v = M;
        for (int i = 0; i < 15; i++) rc[i] = rc[i+1];
        rc[15] = v;
      end
      rdone = taken;
    end
  endtask

  task automatic compare();
    checks++;
    for (int i = 0; i < 16; i++) begin
      if (longint'(cells[31*i +: 31]) != rc[i]) begin
        fails++;
        $display("FAIL %s cell%0d actual %h expected %h", tag, i, cells[31*i +: 31], rc[i]);
      end
    end
    if (step_done != rdone) begin
      fails++;
      $display("FAIL %s step_done actual %0b expected %0b", tag, step_done, rdone);
    end
    if (step_ready != !load_valid) begin
      fails++;
      $display("FAIL R3 step_ready actual %0b expected %0b", step_ready, !load_valid);
    end
  endtask

  // inputs set after a negedge; model updated at posedge; compare at next negedge
  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  function automatic logic [495:0] rnd_cells();
    logic [495:0] r;
    for (int i = 0; i < 16; i++) r[31*i +: 31] = 31'(({$urandom} % M) + 1);
    return r;
  endfunction

  task automatic do_load(input logic [495:0] d);
    load_valid = 1; load_cells = d; cyc(); load_valid = 0;
  endtask

  task automatic do_step(input bit seed, input logic [30:0] w);
    step_valid = 1; step_seed = seed; step_word = w; cyc(); step_valid = 0;
  endtask

  initial begin
    @(negedge clk);
    tag = "R1"; rst = 1; load_valid = 1; load_cells = rnd_cells(); step_valid = 1;
    repeat (3) cyc();
    rst = 0; load_valid = 0; step_valid = 0;
    cyc();
    // R8: all-zero state, running step yields 2^31-1
    tag = "R8"; do_step(0, 31'h1234);
    tag = "R8"; do_step(1, 31'h0);
    // R2, R5, R6: random loads, running steps with random ignored words
    for (int k = 0; k < 6; k++) begin
      tag = "R2"; do_load(rnd_cells());
      tag = "R6"; for (int j = 0; j < 20; j++) do_step(0, 31'($urandom));
    end
    // R7: seeding run
    tag = "R2"; do_load(rnd_cells());
    tag = "R7"; for (int j = 0; j < 32; j++) do_step(1, 31'($urandom));
    // R8: seeding word chosen to make the sum a multiple of the modulus
    for (int k = 0; k < 4; k++) begin
      longint v;
      tag = "R2"; do_load(rnd_cells());
      v = wsum();
      tag = "R8"; do_step(1, 31'((M - v) % M));
    end
    // R3: load and step together, load wins; request held until taken
    tag = "R3";
    step_valid = 1; step_seed = 0; step_word = 31'h55;
    load_valid = 1; load_cells = rnd_cells(); cyc();
    load_cells = rnd_cells(); cyc();
    load_valid = 0; tag = "R4"; cyc();
    step_valid = 0;
    // R9: idle hold
    tag = "R9"; repeat (5) cyc();
    tag = "R4"; do_step(1, 31'h7FFF_FFFF); cyc(); do_step(0, 31'h0);
    // random mix
    tag = "R5";
    for (int j = 0; j < 3000; j++) begin
      int r;
      r = $urandom % 100;
      rst = (r == 0);
      load_valid = (r > 0 && r < 8);
      if (load_valid) load_cells = rnd_cells();
      step_valid = ($urandom % 4) != 0;
      step_seed = $urandom % 2;
      step_word = 31'($urandom);
      cyc();
    end
    rst = 0; load_valid = 0; step_valid = 0;
    cyc();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule